// File: doc/BRIEF.md
# Cascadable 8-bit Reload Timer Bank

This block holds four 8-bit down-counting timers that reload themselves. Each one is reached through a byte-addressed register port. A timer has a control byte, a reload byte and a read-only live count. It advances either on every cycle of the I/O clock or on the borrow out of its lower neighbour. With the borrow source, two, three or four neighbours act as one 16-, 24- or 32-bit counter.

Each timer has a one-cycle underflow output. In a linked group, only the highest member raises its output, once per full period of the combined count. Accesses with an illegal size, address or value are refused. Each refusal raises a one-cycle error flag and leaves all state unchanged.

Top module: `cascade_timer_bank`

## Requirements
- R1: After reset, all control, reload and count bytes are zero, and uflow, acc_err and acc_rdata are zero.
- R2: Control bytes sit at 0x00+k, reload bytes at 0x10+k and counts at 0x20+k, for timer k. Read data is registered, right-aligned and valid in the cycle after the request. It is zero in every other cycle.
- R3: acc_size 0, 1 and 2 mean 1, 2 and 4 bytes. A 2-byte access is legal only at timers 0 and 2. A 4-byte access is legal only at timer 0. The lower-numbered timer occupies the more significant byte, for both reads and writes.
- R4: Each of the following raises acc_err in the following cycle, changes no state and returns zero read data: acc_size 3, a misaligned multi-byte access, an unmapped address, a write to a count address, or a multi-byte write to a control address.
- R5: Control byte layout: bit 7 enables counting, bit 6 requests a load, bits 1:0 select the source (00 = I/O clock, 11 = borrow from timer k-1), and bits 5:2 must be zero. A control write is refused as in R4 if it has any of bits 5:2 set, sets both bits 7 and 6, uses source 01 or 10, or puts timer 0 on the borrow source.
- R6: A reload-byte write copies the new value into the count while that timer's bit 7 is clear. While bit 7 is set, the count is untouched, and the new value is used at the next reload.
- R7: A control write with bit 6 set copies the reload byte into the count.
- R8: An I/O-clock timer with bit 7 set decrements on every cycle. At an edge where its group's combined count is 1, every member reloads from its reload byte. The top member's uflow is high in the following cycle, which gives a period equal to the combined reload value.
- R9: A group whose combined count is zero does not count and never raises uflow.
- R10: Timer k joins the group of timer k-1 when it selects the borrow source and has bit 7 set. The combined value is built from the members' bytes with the higher timer more significant. Only the top member of the group pulses uflow.
- R11: A count read returns the reload byte while that timer's bit 7 is clear, and the live count while it is set.
- R12: A timer on the borrow source with bit 7 clear is not linked. It holds its count and leaves its lower neighbour reporting its own underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte address of the first register |
| acc_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| acc_wdata | input | 32 | Write data, right-aligned |
| acc_rdata | output | 32 | Registered read data, right-aligned |
| acc_err | output | 1 | One-cycle refusal flag |
| uflow | output | 4 | One-cycle underflow pulse per timer |

## Verification
Every result is due one edge after its cause. Read data and the error flag appear in the cycle after the request. A count change lands on the edge of the access. An underflow pulse shows in the cycle after the reload edge, so it coincides with the reloaded count.

The bench drives inputs on falling edges and advances its reference model on rising edges. It compares uflow, acc_err and acc_rdata on every falling edge, so each sample sees exactly one registered update. Directed reads and pulse counts over fixed windows add literal expected values for the register layout and the periods.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int MD_CE = 7;
  localparam int MD_LD = 6;
  localparam logic [1:0] SRC_IO   = 2'b00;
  localparam logic [1:0] SRC_CHAIN = 2'b11;
  localparam logic [3:0] GRP_CTRL = 4'h0;
  localparam logic [3:0] GRP_RELD = 4'h1;
  localparam logic [3:0] GRP_CNT  = 4'h2;
endpackage

// File: rtl/tmr_regif.sv
module tmr_regif #(
  parameter int N  = 4,
  parameter int TW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_en,
  input  logic                  acc_wr,
  input  logic [7:0]            acc_addr,
  input  logic [1:0]            acc_size,
  input  logic [N*TW-1:0]       acc_wdata,
  input  logic [N-1:0][TW-1:0]  mode_q,
  input  logic [N-1:0][TW-1:0]  base_q,
  input  logic [N-1:0][TW-1:0]  cnt_q,
  output logic [N-1:0]          mode_we,
  output logic [N-1:0]          base_we,
  output logic [N-1:0][TW-1:0]  lane_val,
  output logic                  acc_err,
  output logic [N*TW-1:0]       acc_rdata
);
  import tmr_pkg::*;
  localparam int IW = $clog2(N);

  logic [3:0]      grp;
  logic [IW-1:0]   idx;
  logic [3:0]      nbytes;
  logic            map_ok, size_ok, val_bad, refuse;
  logic [TW-1:0]   mv;
  logic [N-1:0]    in_win;
  logic [N*TW-1:0] rd_word;

  always_comb begin
    grp    = acc_addr[7:4];
    idx    = acc_addr[IW-1:0];
    map_ok = ((acc_addr[3:0] >> IW) == 4'd0) && (grp <= GRP_CNT);
    case (acc_size)
      2'd0:    nbytes = 4'd1;
      2'd1:    nbytes = 4'd2;
      2'd2:    nbytes = 4'd4;
      default: nbytes = 4'd0;
    endcase
    size_ok = (nbytes != 4'd0) && ((4'(idx) & (nbytes - 4'd1)) == 4'd0)
              && ((4'(idx) + nbytes) <= 4'(N));
    mv = acc_wdata[TW-1:0];
    val_bad = (mv[5:2] != 4'd0) || (mv[MD_CE] && mv[MD_LD])
              || (mv[1:0] != SRC_IO && mv[1:0] != SRC_CHAIN)
              || (idx == '0 && mv[1:0] == SRC_CHAIN);
    refuse = acc_en && (!map_ok || !size_ok
              || (acc_wr && grp == GRP_CNT)
              || (acc_wr && grp == GRP_CTRL && (acc_size != 2'd0 || val_bad)));

    rd_word = '0;
    for (int k = 0; k < N; k++) begin
      int pos;
      in_win[k] = (k >= int'(idx)) && (k < int'(idx) + int'(nbytes));
      pos = int'(nbytes) - 1 - (k - int'(idx));
      if (pos < 0 || pos >= N) pos = 0;
      lane_val[k] = acc_wdata[pos*TW +: TW];
      mode_we[k]  = acc_en && !refuse && acc_wr && grp == GRP_CTRL && in_win[k];
      base_we[k]  = acc_en && !refuse && acc_wr && grp == GRP_RELD && in_win[k];
      if (in_win[k]) begin
        case (grp)
          GRP_CTRL: rd_word[pos*TW +: TW] = mode_q[k];
          GRP_RELD: rd_word[pos*TW +: TW] = base_q[k];
          default:  rd_word[pos*TW +: TW] = mode_q[k][MD_CE] ? cnt_q[k] : base_q[k];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_err   <= 1'b0;
      acc_rdata <= '0;
    end else begin
      acc_err   <= refuse;
      acc_rdata <= (acc_en && !acc_wr && !refuse) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/tmr_chain.sv
module tmr_chain #(
  parameter int N  = 4,
  parameter int TW = 8
) (
  input  logic [N-1:0]          ce,
  input  logic [N-1:0][1:0]     src,
  input  logic [N-1:0][TW-1:0]  cnt_q,
  output logic [N-1:0]          dec,
  output logic [N-1:0]          reload,
  output logic [N-1:0]          top_pulse
);
  import tmr_pkg::*;

  logic [N-1:0] linked, head, up_zero;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      head[k]   = ce[k] && src[k] == SRC_IO;
      linked[k] = (k > 0) && ce[k] && src[k] == SRC_CHAIN;
    end
    // zero-ness of every linked member above k, walked from the top down
    up_zero[N-1] = 1'b1;
    for (int k = N - 2; k >= 0; k--)
      up_zero[k] = linked[k+1] ? ((cnt_q[k+1] == '0) && up_zero[k+1]) : 1'b1;
    // reload and borrow travel upward from the group head
    for (int k = 0; k < N; k++) begin
      logic fire, idle;
      fire = (cnt_q[k] == TW'(1)) && up_zero[k];
      idle = (cnt_q[k] == '0) && up_zero[k];
      if (head[k]) begin
        reload[k] = fire;
        dec[k]    = !fire && !idle;
      end else if (linked[k]) begin
        reload[k] = reload[k-1];
        dec[k]    = dec[k-1] && (cnt_q[k-1] == '0);
      end else begin
        reload[k] = 1'b0;
        dec[k]    = 1'b0;
      end
    end
    for (int k = 0; k < N; k++)
      top_pulse[k] = reload[k] && !((k < N - 1) && linked[k+1]);
  end
endmodule

// File: rtl/tmr_slice.sv
module tmr_slice #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_we,
  input  logic          base_we,
  input  logic [TW-1:0] wr_val,
  input  logic          dec,
  input  logic          reload,
  output logic [TW-1:0] mode_q,
  output logic [TW-1:0] base_q,
  output logic [TW-1:0] cnt_q
);
  import tmr_pkg::*;

  logic [TW-1:0] cnt_nxt;

  always_comb begin
    if (mode_we && wr_val[MD_LD])          cnt_nxt = base_q;
    else if (base_we && !mode_q[MD_CE])    cnt_nxt = wr_val;
    else if (reload)                       cnt_nxt = base_q;
    else if (dec)                          cnt_nxt = cnt_q - TW'(1);
    else                                   cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (mode_we) mode_q <= wr_val;
      if (base_we) base_q <= wr_val;
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/cascade_timer_bank.sv
module cascade_timer_bank #(
  parameter int NUM_TMR = 4,
  parameter int TW      = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_en,
  input  logic                  acc_wr,
  input  logic [7:0]            acc_addr,
  input  logic [1:0]            acc_size,
  input  logic [NUM_TMR*TW-1:0] acc_wdata,
  output logic [NUM_TMR*TW-1:0] acc_rdata,
  output logic                  acc_err,
  output logic [NUM_TMR-1:0]    uflow
);
  import tmr_pkg::*;

  logic [NUM_TMR-1:0][TW-1:0] mode_q, base_q, cnt_q, lane_val;
  logic [NUM_TMR-1:0]         mode_we, base_we, dec, reload, top_pulse, ce;
  logic [NUM_TMR-1:0][1:0]    src;

  tmr_regif #(.N(NUM_TMR), .TW(TW)) u_regif (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .mode_q(mode_q), .base_q(base_q), .cnt_q(cnt_q),
    .mode_we(mode_we), .base_we(base_we), .lane_val(lane_val),
    .acc_err(acc_err), .acc_rdata(acc_rdata)
  );

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
    assign ce[k]  = mode_q[k][MD_CE];
    assign src[k] = mode_q[k][1:0];
    tmr_slice #(.TW(TW)) u_slice (
      .clk(clk), .rst(rst), .mode_we(mode_we[k]), .base_we(base_we[k]),
      .wr_val(lane_val[k]), .dec(dec[k]), .reload(reload[k]),
      .mode_q(mode_q[k]), .base_q(base_q[k]), .cnt_q(cnt_q[k])
    );
  end

  tmr_chain #(.N(NUM_TMR), .TW(TW)) u_chain (
    .ce(ce), .src(src), .cnt_q(cnt_q),
    .dec(dec), .reload(reload), .top_pulse(top_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) uflow <= '0;
    else     uflow <= top_pulse;
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int N  = 4,
  parameter int TW = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 acc_en,
  input logic                 acc_wr,
  input logic [7:0]           acc_addr,
  input logic [1:0]           acc_size,
  input logic                 acc_err,
  input logic [N-1:0]         uflow,
  input logic [N-1:0][TW-1:0] mode_q,
  input logic [N-1:0][TW-1:0] base_q,
  input logic [N-1:0][TW-1:0] cnt_q
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (uflow == '0 && !acc_err));

  a_r4_count_write_refused: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_wr && acc_addr[7:4] == 4'h2) |=> acc_err);

  a_r3_bad_size_refused: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_size == 2'd3) |=> acc_err);

  a_r5_first_never_chained: assert property (@(posedge clk) disable iff (rst)
    mode_q[0][1:0] != 2'b11);

  for (genvar k = 0; k < N; k++) begin : g_k
    a_r5_mode_legal: assert property (@(posedge clk) disable iff (rst)
      (mode_q[k][5:2] == 4'd0 && !(mode_q[k][7] && mode_q[k][6])));

    a_r8_reload_value: assert property (@(posedge clk) disable iff (rst)
      uflow[k] |-> cnt_q[k] == $past(base_q[k]));

    a_r12_stopped_holds: assert property (@(posedge clk) disable iff (rst)
      (!mode_q[k][7] && !(acc_en && acc_wr)) |=> $stable(cnt_q[k]));
  end
endmodule

bind cascade_timer_bank tmr_checker #(.N(NUM_TMR), .TW(TW)) u_chk (.*);

// File: tb/sim_cascade_timer_bank.sv
module sim_cascade_timer_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_err;
  logic [3:0]  uflow;

  int n_chk = 0, n_bad = 0, cycles = 0;
  string tag = "R1";
  logic started = 1'b0;

  always #4 clk = ~clk;

  cascade_timer_bank u0 (
    .clk(clk), .rst(rst), .acc_en(en), .acc_wr(wr), .acc_addr(addr),
    .acc_size(size), .acc_wdata(wdata), .acc_rdata(acc_rdata),
    .acc_err(acc_err), .uflow(uflow)
  );

  // behavioural reference model
  int md[4], bs[4], ct[4];
  logic [3:0]  e_uf;
  logic        e_err;
  logic [31:0] e_rd;

  always @(posedge clk) begin
    int nct[4];
    int nb, g, ix, v, t;
    longint val;
    logic bad, pulse_any;
    logic [3:0] puls;
    logic [31:0] rdv;
    if (rst) begin
      for (int k = 0; k < 4; k++) begin md[k] = 0; bs[k] = 0; ct[k] = 0; end
      e_uf <= '0; e_err <= 1'b0; e_rd <= '0;
    end else begin
      for (int k = 0; k < 4; k++) nct[k] = ct[k];
      puls = '0;
      for (int h = 0; h < 4; h++) begin
        if ((md[h] & 3) == 0 && (md[h] & 128) != 0) begin
          t = h;
          while (t + 1 < 4 && (md[t+1] & 3) == 3 && (md[t+1] & 128) != 0) t++;
          val = 0;
          for (int k = t; k >= h; k--) val = (val << 8) | longint'(ct[k]);
          if (val == 1) begin
            for (int k = h; k <= t; k++) nct[k] = bs[k];
            puls[t] = 1'b1;
          end else if (val != 0) begin
            val = val - 1;
            for (int k = h; k <= t; k++) nct[k] = int'((val >> (8*(k-h))) & 255);
          end
        end
      end
      pulse_any = |puls;
      bad = 1'b0; rdv = '0;
      if (en) begin
        nb = (size == 0) ? 1 : (size == 1) ? 2 : (size == 2) ? 4 : 0;
        g = addr >> 4; ix = addr & 3;
        if ((addr & 8'h0c) != 0 || g > 2 || nb == 0) bad = 1'b1;
        else if (ix % nb != 0) bad = 1'b1;
        if (!bad && wr) begin
          if (g == 2) bad = 1'b1;
          else if (g == 0) begin
            v = wdata & 255;
            if (nb != 1 || (v & 8'h3c) != 0 || (v & 8'hc0) == 8'hc0 ||
                (v & 3) == 1 || (v & 3) == 2 || (ix == 0 && (v & 3) == 3)) bad = 1'b1;
            else begin
              md[ix] = v;
              if ((v & 64) != 0) nct[ix] = bs[ix];
            end
          end else begin
            for (int j = 0; j < nb; j++) begin
              v = int'((wdata >> (8*(nb-1-j))) & 255);
              if ((md[ix+j] & 128) == 0) nct[ix+j] = v;
              bs[ix+j] = v;
            end
          end
        end else if (!bad) begin
          for (int j = 0; j < nb; j++) begin
            int k;
            k = ix + j;
            v = (g == 0) ? md[k] : (g == 1) ? bs[k] : (((md[k] & 128) != 0) ? ct[k] : bs[k]);
            rdv = rdv | (32'(v) << (8*(nb-1-j)));
          end
        end
      end
      for (int k = 0; k < 4; k++) ct[k] = nct[k];
      e_uf  <= puls;
      e_err <= bad;
      e_rd  <= (en && !wr && !bad) ? rdv : '0;
      if (pulse_any) begin end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (started && !rst) begin
      n_chk++;
      if (acc_rdata !== e_rd || acc_err !== e_err || uflow !== e_uf) begin
        n_bad++;
        $display("FAIL %s cycle %0d: uflow %b exp %b, err %b exp %b, rdata %h exp %h",
                 tag, cycles, uflow, e_uf, acc_err, e_err, acc_rdata, e_rd);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic acc(input logic w, input logic [7:0] a, input logic [1:0] s,
                     input logic [31:0] d);
    @(negedge clk);
    en = 1'b1; wr = w; addr = a; size = s; wdata = d;
    @(negedge clk);
    en = 1'b0; wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] s, output logic [31:0] v);
    acc(1'b0, a, s, 32'h0);
    v = acc_rdata;
  endtask

  task automatic dchk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic count_pulses(input int n, input int lane, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (uflow[lane]) c++;
    end
  endtask

  initial begin
    logic [31:0] v;
    int c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    started = 1'b1;

    // R1: reset state seen at the ports
    tag = "R1";
    dchk("R1 uflow after reset", {28'h0, uflow}, 32'h0);
    rd(8'h20, 2'd2, v); dchk("R1 counts zero", v, 32'h0);
    rd(8'h00, 2'd2, v); dchk("R1 modes zero", v, 32'h0);

    // R2 / R3: layout and multi-byte ordering
    tag = "R2";
    acc(1'b1, 8'h10, 2'd0, 32'h11);
    acc(1'b1, 8'h11, 2'd0, 32'h22);
    acc(1'b1, 8'h12, 2'd0, 32'h33);
    acc(1'b1, 8'h13, 2'd0, 32'h44);
    rd(8'h12, 2'd0, v); dchk("R2 single reload byte", v, 32'h33);
    tag = "R3";
    rd(8'h10, 2'd1, v); dchk("R3 pair at 0", v, 32'h1122);
    rd(8'h12, 2'd1, v); dchk("R3 pair at 2", v, 32'h3344);
    rd(8'h10, 2'd2, v); dchk("R3 quad at 0", v, 32'h11223344);
    acc(1'b1, 8'h10, 2'd2, 32'hA1B2C3D4);
    rd(8'h13, 2'd0, v); dchk("R3 quad write low byte to timer 3", v, 32'hD4);
    rd(8'h20, 2'd2, v); dchk("R6 stopped write loaded counts", v, 32'hA1B2C3D4);

    // R4: refused accesses
    tag = "R4";
    acc(1'b0, 8'h11, 2'd1, 32'h0); dchk("R4 odd pair err", {31'h0, acc_err}, 32'h1);
    acc(1'b0, 8'h12, 2'd2, 32'h0); dchk("R4 quad at 2 err", {31'h0, acc_err}, 32'h1);
    acc(1'b0, 8'h10, 2'd3, 32'h0);
    acc(1'b0, 8'h30, 2'd0, 32'h0);
    acc(1'b0, 8'h04, 2'd0, 32'h0);
    acc(1'b1, 8'h20, 2'd0, 32'h55);
    acc(1'b1, 8'h00, 2'd1, 32'h8000);
    rd(8'h20, 2'd0, v); dchk("R4 count write ignored", v, 32'hA1);

    // R5: illegal control values
    tag = "R5";
    acc(1'b1, 8'h01, 2'd0, 32'h84); dchk("R5 reserved bits err", {31'h0, acc_err}, 32'h1);
    acc(1'b1, 8'h01, 2'd0, 32'hC0);
    acc(1'b1, 8'h01, 2'd0, 32'h81);
    acc(1'b1, 8'h00, 2'd0, 32'h83); dchk("R5 timer0 chain err", {31'h0, acc_err}, 32'h1);
    rd(8'h00, 2'd2, v); dchk("R5 modes unchanged", v, 32'h0);

    // R8: single timer period
    tag = "R8";
    acc(1'b1, 8'h10, 2'd0, 32'h05);
    acc(1'b1, 8'h00, 2'd0, 32'h80);
    count_pulses(20, 0, c); dchk("R8 five-cycle period pulses", 32'(c), 32'd4);

    // R11: live count vs reload while running / stopped
    tag = "R11";
    rd(8'h20, 2'd0, v);
    idle(7);
    // R6: reload write while running
    tag = "R6";
    acc(1'b1, 8'h10, 2'd0, 32'h03);
    count_pulses(30, 0, c);
    acc(1'b1, 8'h00, 2'd0, 32'h00);
    tag = "R11";
    rd(8'h20, 2'd0, v); dchk("R11 stopped count reads reload", v, 32'h03);

    // R7: load bit
    tag = "R7";
    acc(1'b1, 8'h11, 2'd0, 32'h0A);
    acc(1'b1, 8'h01, 2'd0, 32'h80);
    idle(4);
    acc(1'b1, 8'h01, 2'd0, 32'h00);
    acc(1'b1, 8'h01, 2'd0, 32'h40);
    acc(1'b1, 8'h01, 2'd0, 32'h80);
    idle(25);
    acc(1'b1, 8'h01, 2'd0, 32'h00);

    // R9: zero reload stays idle
    tag = "R9";
    acc(1'b1, 8'h12, 2'd0, 32'h00);
    acc(1'b1, 8'h02, 2'd0, 32'h80);
    count_pulses(20, 2, c); dchk("R9 zero reload no pulse", 32'(c), 32'd0);
    acc(1'b1, 8'h02, 2'd0, 32'h00);

    // R10: 16-bit chain of timers 0 and 1
    tag = "R10";
    acc(1'b1, 8'h10, 2'd1, 32'h0201);
    acc(1'b1, 8'h01, 2'd0, 32'h83);
    acc(1'b1, 8'h00, 2'd0, 32'h80);
    count_pulses(600, 1, c); dchk("R10 chain of 258 top pulses", 32'(c), 32'd2);
    count_pulses(100, 0, c); dchk("R10 lower member silent", 32'(c), 32'd0);
    acc(1'b1, 8'h00, 2'd0, 32'h00);
    acc(1'b1, 8'h01, 2'd0, 32'h00);

    // R10: 32-bit chain with small value, then 24-bit chain headed by timer 1
    acc(1'b1, 8'h10, 2'd2, 32'h03000000);
    acc(1'b1, 8'h01, 2'd0, 32'h83);
    acc(1'b1, 8'h02, 2'd0, 32'h83);
    acc(1'b1, 8'h03, 2'd0, 32'h83);
    acc(1'b1, 8'h00, 2'd0, 32'h80);
    count_pulses(30, 3, c); dchk("R10 quad chain top pulses", 32'(c), 32'd10);
    acc(1'b1, 8'h00, 2'd0, 32'h00);
    acc(1'b1, 8'h01, 2'd0, 32'h00);
    acc(1'b1, 8'h11, 2'd0, 32'h02);
    acc(1'b1, 8'h01, 2'd0, 32'h80);
    idle(40);
    acc(1'b1, 8'h01, 2'd0, 32'h00);

    // R12: chain source with enable clear is not linked
    tag = "R12";
    acc(1'b1, 8'h03, 2'd0, 32'h00);
    acc(1'b1, 8'h02, 2'd0, 32'h00);
    acc(1'b1, 8'h10, 2'd1, 32'h0407);
    acc(1'b1, 8'h01, 2'd0, 32'h03);
    acc(1'b1, 8'h00, 2'd0, 32'h80);
    count_pulses(16, 0, c); dchk("R12 lower keeps own pulses", 32'(c), 32'd4);
    rd(8'h21, 2'd0, v); dchk("R12 unlinked count held", v, 32'h07);

    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
endmodule